// File: doc/BRIEF.md
# BPSK Costas Carrier Recovery Loop

This block recovers the carrier of a binary phase-keyed signal. Every valid input sample is multiplied by the cosine and by the negated sine of a local oscillator, giving an in-phase and a quadrature arm. Each arm is smoothed by a single-pole low-pass section. The product of the two smoothed arms is a phase error that does not depend on the data polarity. That error passes through a proportional-plus-integral loop filter, and the filter output is added to a nominal phase increment that drives the block's own phase accumulator.

The oscillator table lives outside the block. The top bits of the phase accumulator leave on `lut_addr`, and the table returns the matching sine and cosine words in the same cycle, combinationally. The block's outputs are the demodulated data sign, the smoothed in-phase arm, the loop control word, a power estimate and a lock flag. The power estimate is the smoothed difference between the squared in-phase arm and the squared quadrature arm. The lock flag is set and cleared with hysteresis on that estimate.

Top module: `costas_bpsk_loop`

## Requirements
- R1: After reset `i_arm_out`, `loop_err`, `power_est`, `lut_addr`, `data_sign` and `locked` are all zero.
- R2: On a valid sample x, the arm inputs are mi = (x*lut_cos) >>> (LUT_W-1) and mq = (-(x*lut_sin)) >>> (LUT_W-1). Each smoothed arm then updates as y = y + ((m - y) >>> ARM_K).
- R3: While `in_valid` is low, no output and no internal state changes.
- R4: `data_sign` is 1 exactly when the smoothed in-phase arm is negative.
- R5: On a valid sample, with I and Q the arm values held before that sample, e = (I*Q) >>> ERR_SHIFT. The integrator adds e >>> KI_SHIFT, and `loop_err` becomes (e >>> KP_SHIFT) plus the new integrator value.
- R6: The integrator saturates at +INT_LIM and -INT_LIM and never wraps.
- R7: On each valid sample the phase accumulator adds `base_inc` plus the `loop_err` held before the sample, modulo 2^PHASE_W. `lut_addr` is the top ADDR_W bits of the accumulator, so a positive loop error makes the phase step larger.
- R8: On a valid sample, p = (I*I - Q*Q) >>> PWR_SHIFT from the arm values held before the sample, and `power_est` updates as y = y + ((p - y) >>> PWR_K).
- R9: `locked` is set on the valid sample that completes LOCK_N consecutive valid samples for which the `power_est` held before each sample exceeds `lock_thr`, compared as signed.
- R10: A valid sample whose prior `power_est` is below `lock_thr >>> 1` clears `locked`. A sample in between leaves `locked` unchanged and restarts the consecutive count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | IN_W | Signed received sample |
| base_inc | input | PHASE_W | Nominal phase increment per sample |
| lock_thr | input | PWR_W | Signed lock threshold for the power estimate |
| lut_addr | output | ADDR_W | Phase address to the oscillator table |
| lut_sin | input | LUT_W | Signed sine word for `lut_addr` |
| lut_cos | input | LUT_W | Signed cosine word for `lut_addr` |
| data_sign | output | 1 | Demodulated bit (1 = negative in-phase arm) |
| i_arm_out | output | ARM_W | Smoothed in-phase arm |
| loop_err | output | PHASE_W | Loop filter output added to the phase step |
| locked | output | 1 | Carrier lock indication |
| power_est | output | PWR_W | Smoothed I squared minus Q squared |

## Verification
On every cycle the assertions check that nothing moves without `in_valid`, that each valid sample advances the phase by the nominal increment plus the prior loop error, that the integrator stays inside its limits, and that the lock flag rises only after an above-threshold estimate and falls after a below-half one. Only the bench scenarios can show the arithmetic itself: the exact arm, error and power trajectories for an in-phase tone, a quadrature offset and a reversed offset. They also show the direction of the frequency correction, the integrator pinned at each limit, and the lock flag held through the hysteresis band.

// File: rtl/costas_pkg.sv
package costas_pkg;

   // Lock monitor states
   typedef enum logic {
      LK_SEARCH = 1'b0,
      LK_HELD   = 1'b1
   } lock_state_e;

   // Width of a counter that must reach n inclusive
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/cl_pole_lpf.sv
// Single-pole smoothing section: y += (x - y) >>> K on each enabled cycle.
module cl_pole_lpf #(
   parameter int W = 16,
   parameter int K = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic signed [W-1:0] x,
   output logic signed [W-1:0] y
);
   localparam int DW = W + 1;

   logic signed [W-1:0]  y_q;
   logic signed [DW-1:0] diff;
   logic signed [DW-1:0] step;

   if (K < 0 || K >= W) begin : g_bad_k
      $error("cl_pole_lpf: K out of range");
   end

   always_comb begin
      diff = DW'(x) - DW'(y_q);
      step = diff >>> K;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  y_q <= '0;
      else if (en) y_q <= y_q + W'(step);
   end

   assign y = y_q;
endmodule

// File: rtl/cl_pi_ctrl.sv
// Proportional-plus-integral loop filter with a clamped integrator.
module cl_pi_ctrl #(
   parameter int ERR_W    = 20,
   parameter int OUT_W    = 24,
   parameter int KP_SHIFT = 2,
   parameter int KI_SHIFT = 6,
   parameter int INT_LIM  = 1 << 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic signed [ERR_W-1:0] err_in,
   output logic signed [OUT_W-1:0] ctl,
   output logic signed [OUT_W-1:0] integ
);
   localparam int SW = OUT_W + 1;
   localparam logic signed [SW-1:0] LIM_P = SW'(INT_LIM);
   localparam logic signed [SW-1:0] LIM_N = -LIM_P;

   logic signed [OUT_W-1:0] integ_q;
   logic signed [OUT_W-1:0] ctl_q;
   logic signed [SW-1:0]    isum;
   logic signed [OUT_W-1:0] integ_nxt;
   logic signed [OUT_W-1:0] prop;

   if (ERR_W > OUT_W) begin : g_bad_w
      $error("cl_pi_ctrl: ERR_W wider than OUT_W");
   end
   if (INT_LIM <= 0 || INT_LIM >= (1 << (OUT_W - 1))) begin : g_bad_lim
      $error("cl_pi_ctrl: INT_LIM out of range");
   end

   always_comb begin
      isum = SW'(integ_q) + SW'(err_in >>> KI_SHIFT);
      if (isum > LIM_P)      integ_nxt = OUT_W'(LIM_P);
      else if (isum < LIM_N) integ_nxt = OUT_W'(LIM_N);
      else                   integ_nxt = OUT_W'(isum);
      prop = OUT_W'(err_in >>> KP_SHIFT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         integ_q <= '0;
         ctl_q   <= '0;
      end else if (en) begin
         integ_q <= integ_nxt;
         ctl_q   <= prop + integ_nxt;
      end
   end

   assign ctl   = ctl_q;
   assign integ = integ_q;
endmodule

// File: rtl/cl_lock_mon.sv
// Lock flag with hysteresis: set after N samples above thr, cleared below thr/2.
module cl_lock_mon
   import costas_pkg::*;
#(
   parameter int W      = 24,
   parameter int LOCK_N = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic signed [W-1:0] pwr,
   input  logic signed [W-1:0] thr,
   output logic                locked
);
   localparam int CW = cnt_width(LOCK_N);

   lock_state_e         st_q;
   logic [CW-1:0]       cnt_q;
   logic signed [W-1:0] half_thr;
   logic                above;
   logic                below_half;

   if (LOCK_N < 1) begin : g_bad_n
      $error("cl_lock_mon: LOCK_N must be at least 1");
   end

   always_comb begin
      half_thr   = thr >>> 1;
      above      = pwr > thr;
      below_half = pwr < half_thr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= LK_SEARCH;
         cnt_q <= '0;
      end else if (en) begin
         if (above) begin
            if (cnt_q != CW'(LOCK_N)) cnt_q <= cnt_q + 1'b1;
            if (cnt_q >= CW'(LOCK_N - 1)) st_q <= LK_HELD;
         end else begin
            cnt_q <= '0;
            if (below_half) st_q <= LK_SEARCH;
         end
      end
   end

   assign locked = (st_q == LK_HELD);
endmodule

// File: rtl/costas_bpsk_loop.sv
// BPSK Costas carrier recovery loop with an external oscillator table.
module costas_bpsk_loop
   import costas_pkg::*;
#(
   parameter int IN_W      = 12,
   parameter int LUT_W     = 12,
   parameter int PHASE_W   = 24,
   parameter int ADDR_W    = 10,
   parameter int ARM_W     = 16,
   parameter int ARM_K     = 3,
   parameter int ERR_SHIFT = 12,
   parameter int ERR_W     = 20,
   parameter int KP_SHIFT  = 2,
   parameter int KI_SHIFT  = 6,
   parameter int INT_LIM   = 1 << 18,
   parameter int PWR_SHIFT = 10,
   parameter int PWR_W     = 24,
   parameter int PWR_K     = 4,
   parameter int LOCK_N    = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [IN_W-1:0]    in_sample,
   input  logic [PHASE_W-1:0] base_inc,
   input  logic [PWR_W-1:0]   lock_thr,
   output logic [ADDR_W-1:0]  lut_addr,
   input  logic [LUT_W-1:0]   lut_sin,
   input  logic [LUT_W-1:0]   lut_cos,
   output logic               data_sign,
   output logic [ARM_W-1:0]   i_arm_out,
   output logic [PHASE_W-1:0] loop_err,
   output logic               locked,
   output logic [PWR_W-1:0]   power_est
);
   localparam int MIX_PW = IN_W + LUT_W + 1;
   localparam int SQ_W   = 2 * ARM_W;
   localparam int DSQ_W  = SQ_W + 1;
   localparam int N_ARMS = 2;

   // elaboration checks
   if (ADDR_W > PHASE_W) begin : g_bad_addr
      $error("costas_bpsk_loop: ADDR_W exceeds PHASE_W");
   end
   if (ARM_W < IN_W + 2) begin : g_bad_arm
      $error("costas_bpsk_loop: ARM_W too narrow for mixer output");
   end
   if (ERR_W < SQ_W - ERR_SHIFT || ERR_W > PHASE_W) begin : g_bad_err
      $error("costas_bpsk_loop: ERR_W inconsistent with ARM_W and PHASE_W");
   end
   if (PWR_W < DSQ_W - PWR_SHIFT) begin : g_bad_pwr
      $error("costas_bpsk_loop: PWR_W too narrow");
   end

   // phase accumulator and table address
   logic [PHASE_W-1:0] phase_q;
   logic signed [PHASE_W-1:0] ctl;
   logic signed [PHASE_W-1:0] integ_val;

   always_ff @(posedge clk) begin
      if (!rst_n)        phase_q <= '0;
      else if (in_valid) phase_q <= phase_q + base_inc + ctl;
   end

   assign lut_addr = phase_q[PHASE_W-1 -: ADDR_W];

   // mixers: cosine arm and negated-sine arm
   logic signed [MIX_PW-1:0] x_ext, cos_ext, sin_ext;
   logic signed [MIX_PW-1:0] prod_i, prod_q;
   logic signed [ARM_W-1:0]  arm_mix [N_ARMS];
   logic signed [ARM_W-1:0]  arm_lpf [N_ARMS];

   always_comb begin
      x_ext   = MIX_PW'($signed(in_sample));
      cos_ext = MIX_PW'($signed(lut_cos));
      sin_ext = MIX_PW'($signed(lut_sin));
      prod_i  = x_ext * cos_ext;
      prod_q  = -(x_ext * sin_ext);
      arm_mix[0] = ARM_W'(prod_i >>> (LUT_W - 1));
      arm_mix[1] = ARM_W'(prod_q >>> (LUT_W - 1));
   end

   for (genvar g = 0; g < N_ARMS; g++) begin : g_arm
      cl_pole_lpf #(
         .W (ARM_W),
         .K (ARM_K)
      ) u_arm_lpf (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (in_valid),
         .x     (arm_mix[g]),
         .y     (arm_lpf[g])
      );
   end

   // arm product (phase detector) and power difference
   logic signed [SQ_W-1:0]  ia_ext, qa_ext, eprod;
   logic signed [ERR_W-1:0] err_raw;
   logic signed [DSQ_W-1:0] i_sq, q_sq, sq_diff;
   logic signed [PWR_W-1:0] pwr_in;
   logic signed [PWR_W-1:0] pwr_lpf;

   always_comb begin
      ia_ext  = SQ_W'(arm_lpf[0]);
      qa_ext  = SQ_W'(arm_lpf[1]);
      eprod   = ia_ext * qa_ext;
      err_raw = ERR_W'(eprod >>> ERR_SHIFT);
      i_sq    = DSQ_W'(ia_ext * ia_ext);
      q_sq    = DSQ_W'(qa_ext * qa_ext);
      sq_diff = i_sq - q_sq;
      pwr_in  = PWR_W'(sq_diff >>> PWR_SHIFT);
   end

   cl_pi_ctrl #(
      .ERR_W    (ERR_W),
      .OUT_W    (PHASE_W),
      .KP_SHIFT (KP_SHIFT),
      .KI_SHIFT (KI_SHIFT),
      .INT_LIM  (INT_LIM)
   ) u_pi (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (in_valid),
      .err_in (err_raw),
      .ctl    (ctl),
      .integ  (integ_val)
   );

   cl_pole_lpf #(
      .W (PWR_W),
      .K (PWR_K)
   ) u_pwr_lpf (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .x     (pwr_in),
      .y     (pwr_lpf)
   );

   cl_lock_mon #(
      .W      (PWR_W),
      .LOCK_N (LOCK_N)
   ) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (in_valid),
      .pwr    (pwr_lpf),
      .thr    ($signed(lock_thr)),
      .locked (locked)
   );

   assign i_arm_out = arm_lpf[0];
   assign data_sign = arm_lpf[0][ARM_W-1];
   assign loop_err  = ctl;
   assign power_est = pwr_lpf;
endmodule

// File: rtl/costas_bpsk_loop_chk.sv
module costas_bpsk_loop_chk #(
   parameter int ADDR_W  = 10,
   parameter int PHASE_W = 24,
   parameter int ARM_W   = 16,
   parameter int PWR_W   = 24,
   parameter int INT_LIM = 1 << 18
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic [PHASE_W-1:0]        base_inc,
   input logic signed [PWR_W-1:0]   lock_thr,
   input logic [ADDR_W-1:0]         lut_addr,
   input logic [ARM_W-1:0]          i_arm_out,
   input logic [PHASE_W-1:0]        loop_err,
   input logic signed [PWR_W-1:0]   power_est,
   input logic                      locked,
   input logic [PHASE_W-1:0]        phase_q,
   input logic signed [PHASE_W-1:0] integ_val
);
   localparam logic signed [PHASE_W-1:0] LIM_P = PHASE_W'(INT_LIM);
   localparam logic signed [PHASE_W-1:0] LIM_N = -LIM_P;

   // R3
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(lut_addr) && $stable(i_arm_out) && $stable(loop_err)
                    && $stable(power_est) && $stable(locked));

   // R7
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> phase_q == $past(phase_q + base_inc + loop_err));

   // R6
   integ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      integ_val <= LIM_P && integ_val >= LIM_N);

   // R9
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(in_valid) && ($past(power_est) > $past(lock_thr)));

   // R10
   lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && locked && (power_est < (lock_thr >>> 1))) |=> !locked);
endmodule

bind costas_bpsk_loop costas_bpsk_loop_chk #(
   .ADDR_W  (ADDR_W),
   .PHASE_W (PHASE_W),
   .ARM_W   (ARM_W),
   .PWR_W   (PWR_W),
   .INT_LIM (INT_LIM)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .base_inc  (base_inc),
   .lock_thr  (lock_thr),
   .lut_addr  (lut_addr),
   .i_arm_out (i_arm_out),
   .loop_err  (loop_err),
   .power_est (power_est),
   .locked    (locked),
   .phase_q   (phase_q),
   .integ_val (integ_val)
);

// File: tb/costas_bpsk_loop_bench.sv
module costas_bpsk_loop_bench;
   localparam int IN_W = 12, LUT_W = 12, PHASE_W = 20, ADDR_W = 20;
   localparam int ARM_W = 16, ARM_K = 3, ERR_SHIFT = 12, ERR_W = 20;
   localparam int KP = 2, KI = 6, LIM = 3000;
   localparam int PWR_SHIFT = 10, PWR_W = 24, PWR_K = 4, LOCK_N = 4;
   localparam longint MASK = (longint'(1) << PHASE_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [IN_W-1:0] in_sample = '0;
   logic [PHASE_W-1:0] base_inc = '0;
   logic [PWR_W-1:0] lock_thr = '0;
   logic [ADDR_W-1:0] lut_addr;
   logic [LUT_W-1:0] lut_sin, lut_cos;
   logic data_sign, locked;
   logic [ARM_W-1:0] i_arm_out;
   logic [PHASE_W-1:0] loop_err;
   logic [PWR_W-1:0] power_est;

   int total = 0;
   int bad = 0;

   // bench acts as the oscillator table: constant words, loop opened
   longint m_cos = 0, m_sin = 0;
   assign lut_cos = LUT_W'(m_cos);
   assign lut_sin = LUT_W'(m_sin);

   // reference model state
   longint m_i = 0, m_q = 0, m_integ = 0, m_err = 0, m_phase = 0;
   longint m_pwr = 0, m_cnt = 0, m_lock = 0, m_e_last = 0;

   always #5 clk = ~clk;

   costas_bpsk_loop #(
      .IN_W(IN_W), .LUT_W(LUT_W), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W),
      .ARM_W(ARM_W), .ARM_K(ARM_K), .ERR_SHIFT(ERR_SHIFT), .ERR_W(ERR_W),
      .KP_SHIFT(KP), .KI_SHIFT(KI), .INT_LIM(LIM), .PWR_SHIFT(PWR_SHIFT),
      .PWR_W(PWR_W), .PWR_K(PWR_K), .LOCK_N(LOCK_N)
   ) u_costas_bpsk_loop (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .base_inc(base_inc), .lock_thr(lock_thr), .lut_addr(lut_addr),
      .lut_sin(lut_sin), .lut_cos(lut_cos), .data_sign(data_sign),
      .i_arm_out(i_arm_out), .loop_err(loop_err), .locked(locked),
      .power_est(power_est)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint s_arm();  return longint'($signed(i_arm_out)); endfunction
   function automatic longint s_err();  return longint'($signed(loop_err));  endfunction
   function automatic longint s_pwr();  return longint'($signed(power_est)); endfunction

   // one valid sample, model update, compare at the following falling edge
   task automatic push(input longint x);
      longint oi, oq, mi, mq, e, p, op, thr, ii;
      in_sample = IN_W'(x);
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid  = 1'b0;
      oi = m_i; oq = m_q; op = m_pwr;
      mi = (x * m_cos) >>> (LUT_W - 1);
      mq = (-(x * m_sin)) >>> (LUT_W - 1);
      m_i = oi + ((mi - oi) >>> ARM_K);
      m_q = oq + ((mq - oq) >>> ARM_K);
      e = (oi * oq) >>> ERR_SHIFT;
      m_e_last = e;
      m_phase = (m_phase + longint'(base_inc) + m_err) & MASK;
      ii = m_integ + (e >>> KI);
      if (ii > LIM) ii = LIM;
      if (ii < -LIM) ii = -LIM;
      m_integ = ii;
      m_err = (e >>> KP) + m_integ;
      p = (oi * oi - oq * oq) >>> PWR_SHIFT;
      m_pwr = op + ((p - op) >>> PWR_K);
      thr = longint'($signed(lock_thr));
      if (op > thr) begin
         if (m_cnt != LOCK_N) m_cnt++;
         if (m_cnt == LOCK_N) m_lock = 1;
      end else begin
         m_cnt = 0;
         if (op < (thr >>> 1)) m_lock = 0;
      end
      check("R2 in-phase arm", s_arm(), m_i);
      check("R4 data sign", longint'(data_sign), (m_i < 0) ? 1 : 0);
      check("R5 loop error", s_err(), m_err);
      check("R7 table address", longint'(lut_addr), m_phase);
      check("R8 power estimate", s_pwr(), m_pwr);
      check("R9 lock flag", longint'(locked), m_lock);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset i arm", s_arm(), 0);
      check("R1 reset loop error", s_err(), 0);
      check("R1 reset power", s_pwr(), 0);
      check("R1 reset address", longint'(lut_addr), 0);
      check("R1 reset lock", longint'(locked), 0);
      check("R1 reset data sign", longint'(data_sign), 0);
   endtask

   task automatic t_idle();
      longint a0, e0, i0, p0;
      base_inc = PHASE_W'(300);
      m_cos = 2047; m_sin = 0;
      for (int k = 0; k < 6; k++) push(900);
      a0 = longint'(lut_addr); e0 = s_err(); i0 = s_arm(); p0 = s_pwr();
      in_sample = IN_W'(-1500);
      repeat (8) @(negedge clk);
      check("R3 idle address", longint'(lut_addr), a0);
      check("R3 idle loop error", s_err(), e0);
      check("R3 idle i arm", s_arm(), i0);
      check("R3 idle power", s_pwr(), p0);
   endtask

   task automatic t_inphase();
      m_cos = 2047; m_sin = 0;
      for (int k = 0; k < 30; k++) push(1500);
      check("R4 positive symbol sign", longint'(data_sign), 0);
      check("R5 no quadrature error", s_err(), 0);
      for (int k = 0; k < 30; k++) push(-1500);
      check("R4 negative symbol sign", longint'(data_sign), 1);
      check("R2 arm settled negative", (s_arm() < -1400) ? 1 : 0, 1);
   endtask

   task automatic t_quad();
      longint a0, d;
      m_cos = 1448; m_sin = -1448;
      for (int k = 0; k < 40; k++) push(1800);
      check("R5 positive loop error", (s_err() > 0) ? 1 : 0, 1);
      a0 = longint'(lut_addr);
      push(1800);
      d = (longint'(lut_addr) - a0) & MASK;
      check("R7 step above nominal", (d > longint'(base_inc)) ? 1 : 0, 1);
   endtask

   task automatic t_sat();
      int guard;
      guard = 0;
      while (m_integ != LIM && guard < 4000) begin
         push(1800);
         guard++;
      end
      for (int k = 0; k < 5; k++) push(1800);
      check("R6 integrator pinned high", s_err() - (m_e_last >>> KP), LIM);
      m_sin = 1448;
      guard = 0;
      while (m_integ != -LIM && guard < 4000) begin
         push(1800);
         guard++;
      end
      for (int k = 0; k < 5; k++) push(1800);
      check("R6 integrator pinned low", s_err() - (m_e_last >>> KP), -LIM);
      check("R5 negative loop error", (s_err() < 0) ? 1 : 0, 1);
   endtask

   task automatic t_lock();
      lock_thr = PWR_W'(2000);
      m_cos = 2047; m_sin = 0;
      for (int k = 0; k < 90; k++) push(1800);
      check("R9 lock after strong tone", longint'(locked), 1);
      for (int k = 0; k < 150; k++) push(1100);
      check("R10 lock held in band", longint'(locked), 1);
      check("R10 power in band", (s_pwr() > 1000 && s_pwr() <= 2000) ? 1 : 0, 1);
      for (int k = 0; k < 120; k++) push(0);
      check("R10 lock released", longint'(locked), 0);
      for (int k = 0; k < 90; k++) push(1800);
      check("R9 relock", longint'(locked), 1);
   endtask

   initial begin
      #(200000 * 10);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_idle();
      t_inphase();
      t_quad();
      t_sat();
      t_lock();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule